// File: doc/BRIEF.md
# Multi-Cycle Integer Multiplier with Paired Result Registers

This block is the multiply unit of a 32-bit processor core. It keeps a 64-bit architectural result as two 32-bit halves: an upper register and a lower register. A request carries a 6-bit major opcode, a 6-bit function field and two 32-bit operands. It is accepted on a valid/ready handshake.

Arithmetic requests form the full 64-bit product with a shift-and-add engine that runs a fixed number of cycles. The unit can then do one of three things with the product:
- replace the register pair with the product;
- add the product to the concatenated pair;
- subtract the product from the concatenated pair.

Each of these exists in a signed form and an unsigned form. Move requests copy a source operand into one half, or return one half on a registered read port.

While a product is being formed the unit is busy and refuses every new request. A read of either half is therefore held off until the pair carries the final value. The control is a four-state machine:
- **IDLE**: accepts requests.
- **STEP**: runs one shift-and-add iteration per cycle.
- **SIGN**: applies the sign correction.
- **ACC**: writes the register pair.

The transitions are:
- IDLE→STEP on an accepted arithmetic request.
- STEP→STEP until the last iteration.
- STEP→SIGN after the last iteration.
- SIGN→ACC always.
- ACC→IDLE always.

Top module: `mdu_top`

## Requirements
- R1: After reset `busy` is 0, `in_ready` is 1, and both halves read back as 0.
- R2: Major 0x00 with function 0x18 stores the signed 64-bit product of `in_a` and `in_b`, with the upper 32 bits in the upper register and the lower 32 bits in the lower register.
- R3: Major 0x00 with function 0x19 does the same with both operands taken as unsigned.
- R4: Major 0x1C with function 0x00 (signed) or 0x01 (unsigned) adds the 64-bit product to {upper, lower}, modulo 2^64.
- R5: Major 0x1C with function 0x04 (signed) or 0x05 (unsigned) subtracts the 64-bit product from {upper, lower}, modulo 2^64.
- R6: Major 0x00 with function 0x10 (upper) or 0x12 (lower) makes `rd_valid` high for exactly the cycle after acceptance, with `rd_data` equal to that half.
- R7: Major 0x00 with function 0x11 (upper) or 0x13 (lower) writes `in_a` into that half at the acceptance edge. It does not raise `busy` or `rd_valid`.
- R8: An accepted arithmetic request raises `busy` in the next cycle. `busy` then stays high for exactly DATA_W+2 cycles (34 by default), and the pair carries the new value when `busy` falls.
- R9: While `busy` is high, `in_ready` is 0 and `rd_valid` is 0. A read presented during that time is accepted only afterwards and returns the updated value.
- R10: Any other major/function pair is accepted and has no effect: the halves are unchanged, and neither `busy` nor `rd_valid` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request accepted this cycle when valid |
| in_major | input | 6 | Major opcode of the request |
| in_func | input | 6 | Function field of the request |
| in_a | input | DATA_W | First operand; source for moves into a half |
| in_b | input | DATA_W | Second operand |
| busy | output | 1 | Product being formed |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | DATA_W | Value of the half that was read |

## Verification
Two functions can meet in the same cycle: the end of a product and a read of the register pair. The read is held off by `in_ready` while the multiply completes. The bench provokes this by presenting a read of the upper or lower half directly behind a multiply, multiply-add or multiply-subtract, so that the read waits with `valid` high across the whole busy window. The scoreboard judges it by requiring that the read returns the post-update half, and that no read response appears while `busy` is high. A move into a half that directly follows a busy window is also checked, so that the final write of the pair and a single-half write are shown not to collide.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

    localparam int FIELD_W = 6;

    localparam logic [FIELD_W-1:0] MAJ_BASE  = 6'h00;
    localparam logic [FIELD_W-1:0] MAJ_ACCUM = 6'h1C;

    localparam logic [FIELD_W-1:0] FN_RD_HI  = 6'h10;
    localparam logic [FIELD_W-1:0] FN_WR_HI  = 6'h11;
    localparam logic [FIELD_W-1:0] FN_RD_LO  = 6'h12;
    localparam logic [FIELD_W-1:0] FN_WR_LO  = 6'h13;
    localparam logic [FIELD_W-1:0] FN_MUL_S  = 6'h18;
    localparam logic [FIELD_W-1:0] FN_MUL_U  = 6'h19;
    localparam logic [FIELD_W-1:0] FN_ADD_S  = 6'h00;
    localparam logic [FIELD_W-1:0] FN_ADD_U  = 6'h01;
    localparam logic [FIELD_W-1:0] FN_SUB_S  = 6'h04;
    localparam logic [FIELD_W-1:0] FN_SUB_U  = 6'h05;

    typedef enum logic [2:0] {
        K_NONE,
        K_MUL,
        K_MADD,
        K_MSUB,
        K_RDHI,
        K_RDLO,
        K_WRHI,
        K_WRLO
    } kind_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_STEP,
        ST_SIGN,
        ST_ACC
    } state_t;

    typedef enum logic [1:0] {
        WB_SET,
        WB_ADD,
        WB_SUB
    } wb_mode_t;

    typedef struct packed {
        kind_t kind;
        logic  sgn;
    } dec_t;

endpackage

// File: rtl/mdu_decode.sv
module mdu_decode
    import mdu_pkg::*;
(
    input  logic [FIELD_W-1:0] major,
    input  logic [FIELD_W-1:0] func,
    output dec_t               dec
);

    always_comb begin
        dec.kind = K_NONE;
        dec.sgn  = 1'b0;
        if (major == MAJ_BASE) begin
            case (func)
                FN_MUL_S: begin dec.kind = K_MUL;  dec.sgn = 1'b1; end
                FN_MUL_U: begin dec.kind = K_MUL;  dec.sgn = 1'b0; end
                FN_RD_HI: dec.kind = K_RDHI;
                FN_RD_LO: dec.kind = K_RDLO;
                FN_WR_HI: dec.kind = K_WRHI;
                FN_WR_LO: dec.kind = K_WRLO;
                default:  dec.kind = K_NONE;
            endcase
        end else if (major == MAJ_ACCUM) begin
            case (func)
                FN_ADD_S: begin dec.kind = K_MADD; dec.sgn = 1'b1; end
                FN_ADD_U: begin dec.kind = K_MADD; dec.sgn = 1'b0; end
                FN_SUB_S: begin dec.kind = K_MSUB; dec.sgn = 1'b1; end
                FN_SUB_U: begin dec.kind = K_MSUB; dec.sgn = 1'b0; end
                default:  dec.kind = K_NONE;
            endcase
        end
    end

endmodule

// File: rtl/mdu_shift_core.sv
// Unsigned shift-and-add engine on operand magnitudes.
// One multiplier bit is retired per step.
module mdu_shift_core #(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           step,
    input  logic           sgn,
    input  logic [W-1:0]   op_a,
    input  logic [W-1:0]   op_b,
    output logic [2*W-1:0] mag_prod,
    output logic           neg
);

    localparam int PW = 2 * W;

    logic [1:0][W-1:0] ops;
    logic [1:0][W-1:0] mags;

    assign ops[0] = op_a;
    assign ops[1] = op_b;

    // Magnitude of each operand; negation applies only to signed requests.
    generate
        for (genvar g = 0; g < 2; g++) begin : g_mag
            assign mags[g] = (sgn && ops[g][W-1]) ? (~ops[g] + 1'b1) : ops[g];
        end
    endgenerate

    logic [W-1:0]  mcand_q;
    logic [PW-1:0] acc_q;
    logic          neg_q;
    logic [W:0]    upper_sum;

    assign upper_sum = {1'b0, acc_q[PW-1:W]} + {1'b0, mcand_q};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mcand_q <= '0;
            acc_q   <= '0;
            neg_q   <= 1'b0;
        end else if (load) begin
            mcand_q <= mags[0];
            acc_q   <= {{W{1'b0}}, mags[1]};
            neg_q   <= sgn & (op_a[W-1] ^ op_b[W-1]);
        end else if (step) begin
            if (acc_q[0]) begin
                acc_q <= {upper_sum, acc_q[W-1:1]};
            end else begin
                acc_q <= {1'b0, acc_q[PW-1:1]};
            end
        end
    end

    assign mag_prod = acc_q;
    assign neg      = neg_q;

endmodule

// File: rtl/mdu_hilo.sv
module mdu_hilo
    import mdu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_hi,
    input  logic           wr_lo,
    input  logic [W-1:0]   wr_data,
    input  logic           wr_pair,
    input  wb_mode_t       mode,
    input  logic [2*W-1:0] prod,
    output logic [W-1:0]   hi,
    output logic [W-1:0]   lo
);

    localparam int PW = 2 * W;

    logic [W-1:0]  hi_q;
    logic [W-1:0]  lo_q;
    logic [PW-1:0] pair_now;
    logic [PW-1:0] pair_new;

    assign pair_now = {hi_q, lo_q};

    always_comb begin
        unique case (mode)
            WB_ADD:  pair_new = pair_now + prod;
            WB_SUB:  pair_new = pair_now - prod;
            default: pair_new = prod;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
        end else if (wr_pair) begin
            hi_q <= pair_new[PW-1:W];
            lo_q <= pair_new[W-1:0];
        end else begin
            if (wr_hi) hi_q <= wr_data;
            if (wr_lo) lo_q <= wr_data;
        end
    end

    assign hi = hi_q;
    assign lo = lo_q;

endmodule

// File: rtl/mdu_top.sv
module mdu_top
    import mdu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [FIELD_W-1:0] in_major,
    input  logic [FIELD_W-1:0] in_func,
    input  logic [DATA_W-1:0]  in_a,
    input  logic [DATA_W-1:0]  in_b,
    output logic               busy,
    output logic               rd_valid,
    output logic [DATA_W-1:0]  rd_data
);

    localparam int PROD_W = 2 * DATA_W;
    localparam int CNT_W  = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(DATA_W - 1);

    dec_t               dec;
    state_t             state_q;
    state_t             state_d;
    logic [CNT_W-1:0]   step_q;
    kind_t              kind_q;
    logic [PROD_W-1:0]  fix_q;
    logic [PROD_W-1:0]  mag_prod;
    logic               prod_neg;
    logic [DATA_W-1:0]  hi_w;
    logic [DATA_W-1:0]  lo_w;
    logic               accept;
    logic               is_arith;
    logic               is_read;
    logic               core_load;
    logic               core_step;
    logic               wr_hi;
    logic               wr_lo;
    logic               wr_pair;
    wb_mode_t           wb_mode;

    mdu_decode u_dec (
        .major (in_major),
        .func  (in_func),
        .dec   (dec)
    );

    mdu_shift_core #(.W(DATA_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (core_load),
        .step     (core_step),
        .sgn      (dec.sgn),
        .op_a     (in_a),
        .op_b     (in_b),
        .mag_prod (mag_prod),
        .neg      (prod_neg)
    );

    mdu_hilo #(.W(DATA_W)) u_hilo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_hi   (wr_hi),
        .wr_lo   (wr_lo),
        .wr_data (in_a),
        .wr_pair (wr_pair),
        .mode    (wb_mode),
        .prod    (fix_q),
        .hi      (hi_w),
        .lo      (lo_w)
    );

    assign accept   = in_valid && in_ready;
    assign is_arith = (dec.kind == K_MUL) || (dec.kind == K_MADD) || (dec.kind == K_MSUB);
    assign is_read  = (dec.kind == K_RDHI) || (dec.kind == K_RDLO);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept && is_arith) state_d = ST_STEP;
            ST_STEP: if (step_q == LAST_STEP) state_d = ST_SIGN;
            ST_SIGN: state_d = ST_ACC;
            ST_ACC:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Outputs and control strobes
    always_comb begin
        in_ready  = 1'b0;
        busy      = 1'b1;
        core_load = 1'b0;
        core_step = 1'b0;
        wr_hi     = 1'b0;
        wr_lo     = 1'b0;
        wr_pair   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                in_ready  = 1'b1;
                busy      = 1'b0;
                core_load = accept && is_arith;
                wr_hi     = accept && (dec.kind == K_WRHI);
                wr_lo     = accept && (dec.kind == K_WRLO);
            end
            ST_STEP: core_step = 1'b1;
            ST_SIGN: ;
            ST_ACC:  wr_pair = 1'b1;
            default: ;
        endcase
    end

    always_comb begin
        unique case (kind_q)
            K_MADD:  wb_mode = WB_ADD;
            K_MSUB:  wb_mode = WB_SUB;
            default: wb_mode = WB_SET;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q   <= '0;
            kind_q   <= K_NONE;
            fix_q    <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= accept && is_read;
            if (accept && is_read) begin
                rd_data <= (dec.kind == K_RDHI) ? hi_w : lo_w;
            end
            if (core_load) begin
                step_q <= '0;
                kind_q <= dec.kind;
            end else if (core_step) begin
                step_q <= step_q + 1'b1;
            end
            if (state_q == ST_SIGN) begin
                fix_q <= prod_neg ? (~mag_prod + 1'b1) : mag_prod;
            end
        end
    end

endmodule

// File: rtl/mdu_top_chk.sv
module mdu_top_chk
    import mdu_pkg::*;
#(
    parameter int W = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic               in_ready,
    input logic [FIELD_W-1:0] in_major,
    input logic [FIELD_W-1:0] in_func,
    input logic [W-1:0]       in_a,
    input logic               busy,
    input logic               rd_valid,
    input logic [W-1:0]       hi_val,
    input logic [W-1:0]       lo_val
);

    localparam int RUN_W = $clog2(W + 4) + 1;
    localparam logic [RUN_W-1:0] BUSY_LEN = RUN_W'(W + 2);

    logic acc;
    logic base;
    logic accum;
    logic arith_req;
    logic read_req;
    logic wrhi_req;
    logic wrlo_req;
    logic none_req;
    logic [RUN_W-1:0] run_q;

    assign acc       = in_valid && in_ready;
    assign base      = (in_major == MAJ_BASE);
    assign accum     = (in_major == MAJ_ACCUM);
    assign arith_req = (base && (in_func == FN_MUL_S || in_func == FN_MUL_U)) ||
                       (accum && (in_func == FN_ADD_S || in_func == FN_ADD_U ||
                                  in_func == FN_SUB_S || in_func == FN_SUB_U));
    assign read_req  = base && (in_func == FN_RD_HI || in_func == FN_RD_LO);
    assign wrhi_req  = base && (in_func == FN_WR_HI);
    assign wrlo_req  = base && (in_func == FN_WR_LO);
    assign none_req  = !(arith_req || read_req || wrhi_req || wrlo_req);

    always_ff @(posedge clk) begin
        if (!rst_n)    run_q <= '0;
        else if (busy) run_q <= run_q + 1'b1;
        else           run_q <= '0;
    end

    p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!busy && in_ready));

    p_busy_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && arith_req) |=> busy);

    p_busy_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_q == BUSY_LEN));

    p_busy_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_q < BUSY_LEN));

    p_hold_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !in_ready);

    p_no_read_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !busy);

    p_read_return_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && read_req) |=> rd_valid);

    p_write_hi_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && wrhi_req) |=> (hi_val == $past(in_a) && !busy && !rd_valid));

    p_write_lo_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && wrlo_req) |=> (lo_val == $past(in_a) && !busy && !rd_valid));

    p_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && none_req) |=> (!busy && !rd_valid && $stable(hi_val) && $stable(lo_val)));

endmodule

bind mdu_top mdu_top_chk #(.W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_major (in_major),
    .in_func  (in_func),
    .in_a     (in_a),
    .busy     (busy),
    .rd_valid (rd_valid),
    .hi_val   (hi_w),
    .lo_val   (lo_w)
);

// File: tb/mdu_top_test.sv
`timescale 1ns/1ps
module mdu_top_test;

    localparam int W   = 32;
    localparam int LAT = W + 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [5:0]   in_major = '0;
    logic [5:0]   in_func = '0;
    logic [W-1:0] in_a = '0;
    logic [W-1:0] in_b = '0;
    logic         busy;
    logic         rd_valid;
    logic [W-1:0] rd_data;

    always #2.5 clk = ~clk;

    mdu_top #(.DATA_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_major(in_major), .in_func(in_func), .in_a(in_a), .in_b(in_b),
        .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    int          n_chk = 0;
    int          n_fail = 0;
    logic [63:0] model = '0;
    logic [W-1:0] exp_q[$];
    string        tag_q[$];

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    function automatic logic [63:0] prod64(input logic [W-1:0] a, input logic [W-1:0] b, input bit s);
        logic [63:0] ea;
        logic [63:0] eb;
        ea = s ? {{32{a[W-1]}}, a} : {32'h0, a};
        eb = s ? {{32{b[W-1]}}, b} : {32'h0, b};
        return ea * eb;
    endfunction

    // Driver: presents a request, waits for acceptance, updates the model
    // and pushes the expected read value into the scoreboard queue.
    task automatic issue(input logic [5:0] maj, input logic [5:0] fn,
                         input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
        @(negedge clk);
        in_valid = 1'b1; in_major = maj; in_func = fn; in_a = a; in_b = b;
        while (!in_ready) @(negedge clk);
        if (maj == 6'h00 && fn == 6'h18) model = prod64(a, b, 1'b1);
        else if (maj == 6'h00 && fn == 6'h19) model = prod64(a, b, 1'b0);
        else if (maj == 6'h1C && fn == 6'h00) model = model + prod64(a, b, 1'b1);
        else if (maj == 6'h1C && fn == 6'h01) model = model + prod64(a, b, 1'b0);
        else if (maj == 6'h1C && fn == 6'h04) model = model - prod64(a, b, 1'b1);
        else if (maj == 6'h1C && fn == 6'h05) model = model - prod64(a, b, 1'b0);
        else if (maj == 6'h00 && fn == 6'h11) model[63:32] = a;
        else if (maj == 6'h00 && fn == 6'h13) model[31:0] = a;
        else if (maj == 6'h00 && fn == 6'h10) begin exp_q.push_back(model[63:32]); tag_q.push_back(tag); end
        else if (maj == 6'h00 && fn == 6'h12) begin exp_q.push_back(model[31:0]); tag_q.push_back(tag); end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic read_both(input string tag);
        issue(6'h00, 6'h10, '0, '0, {tag, " upper"});
        issue(6'h00, 6'h12, '0, '0, {tag, " lower"});
    endtask

    // Arithmetic request with busy-window measurement (R8, R9)
    task automatic timed(input logic [5:0] maj, input logic [5:0] fn,
                         input logic [W-1:0] a, input logic [W-1:0] b);
        int  n = 0;
        bit  ready_seen = 1'b0;
        issue(maj, fn, a, b, "");
        while (busy) begin
            if (in_ready) ready_seen = 1'b1;
            n++;
            @(negedge clk);
        end
        chk(n == LAT, "R8 busy length", 64'(n), 64'(LAT));
        chk(!ready_seen, "R9 ready low while busy", 64'(ready_seen), 64'd0);
    endtask

    // Monitor: compares every read response against the scoreboard queue
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R10 unexpected read response", 64'(rd_data), 64'd0);
            end else begin
                logic [W-1:0] e;
                string        t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(rd_data == e, {"R6 ", t}, 64'(rd_data), 64'(e));
            end
            chk(!busy, "R9 read while busy", 64'(busy), 64'd0);
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog expired", 64'd0, 64'd1);
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(busy == 1'b0, "R1 busy after reset", 64'(busy), 64'd0);
        chk(in_ready == 1'b1, "R1 ready after reset", 64'(in_ready), 64'd1);
        read_both("R1 reset value");

        // R2 signed multiply, several sign patterns
        timed(6'h00, 6'h18, 32'hFFFF_FFFF, 32'h0000_0001);
        read_both("R2 -1*1");
        timed(6'h00, 6'h18, 32'h8000_0000, 32'h8000_0000);
        read_both("R2 min*min");
        timed(6'h00, 6'h18, 32'h0001_2345, 32'hFFF0_0000);
        read_both("R2 pos*neg");
        // R3 unsigned multiply
        timed(6'h00, 6'h19, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        read_both("R3 max*max");
        timed(6'h00, 6'h19, 32'h8000_0000, 32'h0000_0002);
        read_both("R3 carry into upper");
        // R7 moves into halves, then R4 accumulate
        issue(6'h00, 6'h11, 32'h0000_0001, '0, "");
        issue(6'h00, 6'h13, 32'hFFFF_FFFF, '0, "");
        read_both("R7 move-in");
        timed(6'h1C, 6'h00, 32'hFFFF_FFFE, 32'h0000_0003);
        read_both("R4 signed accumulate");
        timed(6'h1C, 6'h01, 32'hFFFF_FFFE, 32'h0000_0003);
        read_both("R4 unsigned accumulate");
        // R5 subtract
        timed(6'h1C, 6'h04, 32'h7FFF_FFFF, 32'h8000_0000);
        read_both("R5 signed subtract");
        timed(6'h1C, 6'h05, 32'h7FFF_FFFF, 32'h8000_0000);
        read_both("R5 unsigned subtract");
        // R9 read presented immediately behind a multiply: held off
        issue(6'h00, 6'h18, 32'h1234_5678, 32'h9ABC_DEF0, "");
        issue(6'h00, 6'h10, '0, '0, "R9 held upper read");
        issue(6'h1C, 6'h05, 32'hDEAD_BEEF, 32'h0000_1000, "");
        issue(6'h00, 6'h12, '0, '0, "R9 held lower read");
        // Move-in directly behind a busy window
        issue(6'h1C, 6'h00, 32'h0000_0005, 32'h0000_0007, "");
        issue(6'h00, 6'h13, 32'hCAFE_F00D, '0, "");
        read_both("R7 move after accumulate");
        // R10 unrecognised codes have no effect
        issue(6'h00, 6'h3F, 32'h1111_1111, 32'h2222_2222, "");
        chk(busy == 1'b0, "R10 no busy", 64'(busy), 64'd0);
        issue(6'h1C, 6'h02, 32'h3333_3333, 32'h4444_4444, "");
        issue(6'h05, 6'h18, 32'h5555_5555, 32'h6666_6666, "");
        read_both("R10 unchanged");
        // Mixed random sequence
        for (int i = 0; i < 24; i++) begin
            logic [5:0] maj;
            logic [5:0] fn;
            int sel;
            sel = $urandom_range(0, 5);
            maj = (sel < 2) ? 6'h00 : 6'h1C;
            case (sel)
                0: fn = 6'h18;
                1: fn = 6'h19;
                2: fn = 6'h00;
                3: fn = 6'h01;
                4: fn = 6'h04;
                default: fn = 6'h05;
            endcase
            issue(maj, fn, $urandom, $urandom, "");
            read_both("R2 R3 R4 R5 random");
        end
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R6 all reads returned", 64'(exp_q.size()), 64'd0);
        summary();
        $finish;
    end

endmodule